// File: doc/BRIEF.md
# Control Transfer History Ring

This block keeps a short history of control-flow transfers (calls, returns, jumps, branches, traps and trap returns) in a circular store. Each record holds a source PC, a target PC and a metadata word. Qualification and privilege filtering happen upstream. A single strobe, `xfer_valid`, arrives together with the transfer kind, both PCs and the metadata. The number of records in use is set by a small depth selector.

Software reaches the records through an indirect window. A 12-bit selector in the range 0x200 to 0x2FF names a logical entry: the entry index is the selector minus 0x200, and entry 0 is always the youngest record. The same port accepts writes that replace one record in place. A clear command empties the whole store.

An optional return-stack emulation mode makes the ring behave like a call stack. In this mode only calls add records, and each return pops the most recent call.

Top module: `ctr_ring`

## Requirements
- R1: With `ras_mode`=0, every transfer on `xfer_valid` is recorded, whatever its kind. The kind encodings are 0 call, 1 return, 2 jump, 3 branch, 4 trap and 5 trap return. The record is written at the write pointer, and the pointer then advances by one modulo the active depth.
- R2: Logical entry n reads the n-th youngest record, with entry 0 the youngest. Once the ring is full, new records overwrite the oldest, so only the most recent depth records remain visible.
- R3: The active depth is 16 << `depth_sel` (`depth_sel` 0..4 gives 16, 32, 64, 128 or 256). Any larger `depth_sel` value gives the 256-entry maximum.
- R4: A selector outside 0x200..0x2FF, or a logical index at or above the active depth, reads as zero on all three read outputs, and a write to it is ignored.
- R5: With `ras_mode`=1, only kind 0 (call) adds a record. Jumps, branches, traps and trap returns change nothing.
- R6: With `ras_mode`=1, a return (kind 1) on a non-empty ring removes the youngest record. The popped slot becomes zero and the older records move up one logical index.
- R7: With `ras_mode`=1, a return on an empty ring leaves every entry and the pointer unchanged.
- R8: `clear` zeroes the source, target and metadata of every slot, for all depth settings. Until the next recorded transfer, every read returns zero. A transfer in the same cycle as `clear` is dropped. Reset gives the same empty state.
- R9: A software write (`acc_wr`) replaces the addressed logical entry without moving the write pointer. If `xfer_valid` is high in the same cycle, the transfer takes effect and the write is dropped.
- R10: A change of `depth_sel` takes effect on the next transfer. The pointer then wraps at the new depth, and reads map logical entries using the currently selected depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_valid | input | 1 | Qualified transfer strobe |
| xfer_kind | input | 3 | Transfer kind (0 call, 1 return, 2 jump, 3 branch, 4 trap, 5 trap return) |
| xfer_src | input | PC_W | Source PC of the transfer |
| xfer_dst | input | PC_W | Target PC of the transfer |
| xfer_meta | input | META_W | Metadata word for the record |
| depth_sel | input | 3 | Depth selector, depth = 16 << value |
| ras_mode | input | 1 | Return-stack emulation enable |
| clear | input | 1 | Zero all records |
| acc_sel | input | 12 | Indirect selector, logical entry = value - 0x200 |
| acc_wr | input | 1 | Write strobe for the selected entry |
| acc_wsrc | input | PC_W | Source PC to write |
| acc_wdst | input | PC_W | Target PC to write |
| acc_wmeta | input | META_W | Metadata to write |
| acc_rsrc | output | PC_W | Source PC of the selected entry |
| acc_rdst | output | PC_W | Target PC of the selected entry |
| acc_rmeta | output | META_W | Metadata of the selected entry |

## Verification
The ring is filled past its depth with a mix of all six kinds. The test then sweeps every logical index, which separates a correct youngest-first mapping from an off-by-one or reversed slot order, and shows the wrap-around overwrite. Depth is switched between 16, 32 and the clamped maximum mid-stream, so that wrapping at the old depth can be told apart from wrapping at the new one. Stack mode is driven with calls interleaved with other kinds and with more returns than calls, which exposes records that leak from non-call kinds and underflow on an empty stack. Same-cycle clear, transfer and software write show which of them wins.

// File: rtl/ctr_ring.sv
module ctr_ring #(
  parameter int PC_W     = 32,
  parameter int META_W   = 32,
  parameter int MAX_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_valid,
  input  logic [2:0]        xfer_kind,
  input  logic [PC_W-1:0]   xfer_src,
  input  logic [PC_W-1:0]   xfer_dst,
  input  logic [META_W-1:0] xfer_meta,
  input  logic [2:0]        depth_sel,
  input  logic              ras_mode,
  input  logic              clear,
  input  logic [11:0]       acc_sel,
  input  logic              acc_wr,
  input  logic [PC_W-1:0]   acc_wsrc,
  input  logic [PC_W-1:0]   acc_wdst,
  input  logic [META_W-1:0] acc_wmeta,
  output logic [PC_W-1:0]   acc_rsrc,
  output logic [PC_W-1:0]   acc_rdst,
  output logic [META_W-1:0] acc_rmeta
);
  localparam int MIN_LOG2 = 4;
  localparam int AW       = MAX_LOG2;
  localparam int MAXD     = 1 << MAX_LOG2;
  localparam logic [11:0] WIN_BASE = 12'h200;

  logic [PC_W-1:0]   src_q  [MAXD];
  logic [PC_W-1:0]   dst_q  [MAXD];
  logic [META_W-1:0] meta_q [MAXD];
  logic [AW-1:0]     wptr;
  logic [AW:0]       occ;

  logic [AW:0]   depth;
  logic [AW-1:0] mask;
  always_comb begin
    int lg;
    lg = MIN_LOG2 + int'(depth_sel);
    if (lg > MAX_LOG2) lg = MAX_LOG2;
    depth = (AW+1)'(1) << lg;
  end
  assign mask = AW'(depth - 1'b1);

  logic [AW-1:0] idx, phys, prev;
  logic          in_win, hit;
  assign idx    = acc_sel[AW-1:0];
  assign in_win = acc_sel[11:AW] == WIN_BASE[11:AW];
  assign hit    = in_win && ({1'b0, idx} < depth);
  assign phys   = (wptr - 1'b1 - idx) & mask;
  assign prev   = (wptr - 1'b1) & mask;

  logic [AW:0] occ_eff;
  assign occ_eff = (occ > depth) ? depth : occ;

  logic push, pop, sw;
  assign push = xfer_valid && !clear && (!ras_mode || xfer_kind == 3'd0);
  assign pop  = xfer_valid && !clear && ras_mode && xfer_kind == 3'd1 && occ_eff != '0;
  assign sw   = acc_wr && hit && !xfer_valid && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAXD; i++) begin
        src_q[i]  <= '0;
        dst_q[i]  <= '0;
        meta_q[i] <= '0;
      end
      wptr <= '0;
      occ  <= '0;
    end else if (clear) begin
      for (int i = 0; i < MAXD; i++) begin
        src_q[i]  <= '0;
        dst_q[i]  <= '0;
        meta_q[i] <= '0;
      end
      wptr <= '0;
      occ  <= '0;
    end else if (push) begin
      src_q[wptr & mask]  <= xfer_src;
      dst_q[wptr & mask]  <= xfer_dst;
      meta_q[wptr & mask] <= xfer_meta;
      wptr <= (wptr + 1'b1) & mask;
      occ  <= (occ_eff == depth) ? depth : occ_eff + 1'b1;
    end else if (pop) begin
      src_q[prev]  <= '0;
      dst_q[prev]  <= '0;
      meta_q[prev] <= '0;
      wptr <= prev;
      occ  <= occ_eff - 1'b1;
    end else if (sw) begin
      src_q[phys]  <= acc_wsrc;
      dst_q[phys]  <= acc_wdst;
      meta_q[phys] <= acc_wmeta;
    end
  end

  assign acc_rsrc  = hit ? src_q[phys]  : '0;
  assign acc_rdst  = hit ? dst_q[phys]  : '0;
  assign acc_rmeta = hit ? meta_q[phys] : '0;

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc_rsrc == '0 && acc_rdst == '0 && acc_rmeta == '0));

  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && ras_mode && xfer_kind == 3'd1 && occ == '0 && !clear)
      |=> ($stable(wptr) && occ == '0));

  p_sw_keeps_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !xfer_valid && !clear) |=> ($stable(wptr) && $stable(occ)));

  p_occ_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (AW+1)'(MAXD));

  p_ras_other_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && ras_mode && xfer_kind > 3'd1 && !clear && !acc_wr)
      |=> ($stable(wptr) && $stable(occ)));
endmodule

// File: tb/ctr_ring_tb_top.sv
`timescale 1ns/1ps
module ctr_ring_tb_top;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        xfer_valid = 0, ras_mode = 0, clear = 0, acc_wr = 0;
  logic [2:0]  xfer_kind = 0, depth_sel = 0;
  logic [31:0] xfer_src = 0, xfer_dst = 0, xfer_meta = 0;
  logic [11:0] acc_sel = 12'h200;
  logic [31:0] acc_wsrc = 0, acc_wdst = 0, acc_wmeta = 0;
  logic [31:0] acc_rsrc, acc_rdst, acc_rmeta;

  ctr_ring dut_i (.*);

  int n_chk = 0, n_bad = 0;
  logic [31:0] ms [256], md [256], mm [256];
  int mw = 0, mocc = 0;

  function automatic int m_depth();
    int s = (depth_sel > 4) ? 4 : int'(depth_sel);
    return 16 << s;
  endfunction

  task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic m_clear();
    for (int i = 0; i < 256; i++) begin ms[i] = 0; md[i] = 0; mm[i] = 0; end
    mw = 0; mocc = 0;
  endtask

  task automatic m_xfer(logic [2:0] k, logic [31:0] s, logic [31:0] d, logic [31:0] m);
    int dp = m_depth();
    if (mocc > dp) mocc = dp;
    if (!ras_mode || k == 0) begin
      ms[mw & (dp-1)] = s; md[mw & (dp-1)] = d; mm[mw & (dp-1)] = m;
      mw = (mw + 1) & (dp-1);
      if (mocc < dp) mocc++;
    end else if (k == 1 && mocc > 0) begin
      mw = (mw - 1) & (dp-1);
      ms[mw] = 0; md[mw] = 0; mm[mw] = 0;
      mocc--;
    end
  endtask

  task automatic xfer(logic [2:0] k, logic [31:0] s, logic [31:0] d, logic [31:0] m);
    xfer_valid = 1; xfer_kind = k; xfer_src = s; xfer_dst = d; xfer_meta = m;
    tick();
    xfer_valid = 0;
    m_xfer(k, s, d, m);
  endtask

  task automatic sweep(string tag);
    int dp = m_depth();
    for (int i = 0; i < 256; i++) begin
      logic [95:0] e;
      int p = (mw - 1 - i) & (dp - 1);
      acc_sel = 12'h200 + 12'(i); #1;
      e = (i < dp) ? {ms[p], md[p], mm[p]} : 96'd0;
      chk(tag, {acc_rsrc, acc_rdst, acc_rmeta}, e);
    end
  endtask

  task automatic swr(int i, logic [31:0] s, logic [31:0] d, logic [31:0] m, logic with_x);
    int dp = m_depth();
    acc_sel = 12'h200 + 12'(i); acc_wr = 1; acc_wsrc = s; acc_wdst = d; acc_wmeta = m;
    if (with_x) begin
      xfer_valid = 1; xfer_kind = 3; xfer_src = 32'hAAAA_0000; xfer_dst = 32'hBBBB_0000; xfer_meta = 7;
    end
    tick();
    acc_wr = 0; xfer_valid = 0;
    if (with_x) m_xfer(3, 32'hAAAA_0000, 32'hBBBB_0000, 7);
    else if (i < dp) begin
      int p = (mw - 1 - i) & (dp - 1);
      ms[p] = s; md[p] = d; mm[p] = m;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    m_clear();
    #12 rst_n = 1; #1;
    sweep("R8 reset state zero");

    for (int n = 1; n <= 20; n++)
      xfer(3'(n % 6), 32'h1000_0000 + n, 32'h2000_0000 + n, 32'(n * 3));
    sweep("R1 R2 normal fill and wrap");
    acc_sel = 12'h200; #1;
    chk("R2 entry0 youngest", {acc_rsrc, acc_rdst, acc_rmeta}, {32'h1000_0014, 32'h2000_0014, 32'd60});

    acc_sel = 12'h1FF; #1;
    chk("R4 selector below window", {acc_rsrc, acc_rdst, acc_rmeta}, 96'd0);
    acc_sel = 12'h300; #1;
    chk("R4 selector above window", {acc_rsrc, acc_rdst, acc_rmeta}, 96'd0);
    acc_sel = 12'h300; acc_wr = 1; acc_wsrc = 32'hDEAD; tick(); acc_wr = 0;
    swr(20, 32'hDEAD, 32'hBEEF, 32'h1, 0);
    sweep("R4 writes outside window or depth ignored");

    swr(3, 32'h5555_0003, 32'h6666_0003, 32'h33, 0);
    sweep("R9 software write in place");
    xfer(2, 32'h1000_0015, 32'h2000_0015, 32'd63);
    sweep("R9 pointer unmoved by software write");
    swr(1, 32'h7777_0001, 32'h8888_0001, 32'h11, 1);
    sweep("R9 transfer beats software write");

    depth_sel = 1;
    xfer(4, 32'h1000_0100, 32'h2000_0100, 32'd100);
    sweep("R10 depth 32 after change");
    for (int n = 0; n < 40; n++)
      xfer(2, 32'h3000_0000 + n, 32'h4000_0000 + n, 32'(n));
    sweep("R10 wrap at new depth 32");

    depth_sel = 7;
    for (int n = 0; n < 300; n++)
      xfer(3, 32'h5000_0000 + n, 32'h6000_0000 + n, 32'(n));
    sweep("R3 clamped depth 256");
    depth_sel = 4;
    sweep("R3 depth 256 at selector 4");
    depth_sel = 2;
    sweep("R3 depth 64");

    clear = 1; xfer_valid = 1; xfer_kind = 0; xfer_src = 32'h9; tick();
    clear = 0; xfer_valid = 0; m_clear();
    depth_sel = 7; sweep("R8 clear all depths and drop transfer");
    depth_sel = 0; sweep("R8 clear zero at depth 16");
    xfer(5, 32'hC000_0001, 32'hD000_0001, 32'h5);
    sweep("R8 first transfer after clear");

    clear = 1; tick(); clear = 0; m_clear();
    ras_mode = 1;
    xfer(0, 32'hA1, 32'hB1, 1);
    xfer(2, 32'hA2, 32'hB2, 2);
    xfer(3, 32'hA3, 32'hB3, 3);
    xfer(0, 32'hA4, 32'hB4, 4);
    xfer(4, 32'hA5, 32'hB5, 5);
    xfer(5, 32'hA6, 32'hB6, 6);
    xfer(0, 32'hA7, 32'hB7, 7);
    sweep("R5 stack mode records only calls");
    acc_sel = 12'h202; #1;
    chk("R5 third entry is first call", {acc_rsrc, acc_rdst, acc_rmeta}, {32'hA1, 32'hB1, 32'd1});
    xfer(1, 32'hE1, 32'hF1, 9);
    sweep("R6 return pops youngest");
    acc_sel = 12'h200; #1;
    chk("R6 entry0 after pop", {acc_rsrc, acc_rdst, acc_rmeta}, {32'hA4, 32'hB4, 32'd4});
    xfer(1, 32'hE2, 32'hF2, 9);
    xfer(1, 32'hE3, 32'hF3, 9);
    sweep("R6 stack drained");
    xfer(1, 32'hE4, 32'hF4, 9);
    sweep("R7 return on empty unchanged");
    xfer(0, 32'hA8, 32'hB8, 8);
    sweep("R7 push after empty return");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule